// File: doc/BRIEF.md
# Prioritised Interrupt Controller Bank

This block gathers 32 interrupt request lines, records which of them are pending, and picks one winner for each of two outputs: a normal interrupt line and a fast interrupt line. Each source has its own configuration word. The word chooses the output the source is routed to, sets a 5-bit priority, and selects whether the source is captured on a rising edge or followed as a level. A mask word blocks individual sources. Software reads a sorted-number register for each output to learn which source currently wins. It retires that source by writing the control register.

Software reaches all state through a flat word-addressed register port with address, write data, write enable and combinational read data. Several banks can be placed side by side, and a later bank can drive one request line of bank 0. Only bank 0 may route sources to the fast output, and the `BANK_ID` parameter tells each instance which bank it is. A source with bank-local index `i` in bank `b` has global number `32*b + i`.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask word (address 0x01) reads 0xFFFFFFFF, the status word (address 0x00) reads 0, both sorted-number registers read 0, and both outputs are low.
- R2: The configuration word of source k is at word address 0x20+k. Bit 0 routes the source to the fast output, bit 1 selects edge capture (1) or level (0), and bits 6:2 hold the priority. All other bits read 0.
- R3: When `BANK_ID` is not 0, bit 0 of every configuration word is stored and read back as 0, so every source is routed to the normal output.
- R4: A 1 in mask bit k blocks source k. A source takes part in arbitration and in driving the outputs only when its status bit is 1 and its mask bit is 0.
- R5: For an edge source, the status bit sets on a rising input and stays set after the input falls. For a level source, the status bit equals the input sampled at the previous clock.
- R6: Among the candidates of one output, the smallest priority value wins. On equal priority, the lower source index wins.
- R7: The sorted normal register (0x02) and the sorted fast register (0x03) each read the winning index in bits 4:0 and a 1 in bit 5, or read 0 when that output has no candidate.
- R8: `irqOut` is high when any unmasked pending source is routed to the normal output, and `fiqOut` is high when any is routed to the fast output.
- R9: A write to the control word (0x04) with bit 0 set retires the current normal winner, and with bit 1 set retires the current fast winner. Retiring clears the status bit of an edge source and leaves a level source unchanged.
- R10: A write to the status word clears every edge status bit written as 0 and leaves bits written as 1 unchanged.
- R11: A status bit changes one clock after its cause. The sorted registers and outputs follow one clock after the status bit, so after a retire they still show the old winner until the next clock.
- R12: A rising edge on an edge source that arrives in the same clock as a retire or a status clear of that source leaves its status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 32 | Interrupt request lines, synchronous to clk |
| regAddr | input | 6 | Word address of the register port |
| regWdata | input | 32 | Write data |
| regWe | input | 1 | Write enable, one write per clock |
| regRdata | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
A retire or a status-clear write can fall in the same clock as a new rising edge on the very source being cleared. If the clear is applied last, that new request is lost. The bench produces this case by first latching source 3, then letting its input fall, and then raising the input again in the same cycle as the control write. It judges the result by reading the status word in the next cycle and the sorted register two cycles later: source 3 must still be pending and still winning. A constrained random phase then mixes input changes, configuration writes, retires and status writes. After each step it compares every readable result against a bench model.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int SRC_N  = 32;
  localparam int PRIO_W = 5;
  localparam int IDX_W  = $clog2(SRC_N);
  localparam int ADDR_W = $clog2(2 * SRC_N);
  localparam int DATA_W = 32;

  localparam int ADDR_STATUS   = 0;
  localparam int ADDR_MASK     = 1;
  localparam int ADDR_SORT_IRQ = 2;
  localparam int ADDR_SORT_FIQ = 3;
  localparam int ADDR_CTRL     = 4;

  localparam int CFG_FAST_BIT = 0;
  localparam int CFG_EDGE_BIT = 1;
  localparam int CFG_PRIO_LSB = 2;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] prio;
  } winner_t;

  typedef struct packed {
    logic ackIrq;
    logic ackFiq;
    logic statusWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
  parameter int N  = 32,
  parameter int PW = 5,
  localparam int IW = $clog2(N),
  localparam int NODES = 2 * N - 1
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 winValid,
  output logic [IW-1:0]        winIdx,
  output logic [PW-1:0]        winPrio
);
  // Heap-ordered comparison tree; left child always holds lower indices,
  // so taking the right child only on strictly smaller priority breaks ties low.
  logic          nValid [NODES];
  logic [IW-1:0] nIdx   [NODES];
  logic [PW-1:0] nPrio  [NODES];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      nValid[N-1+k] = cand[k];
      nIdx[N-1+k]   = IW'(k);
      nPrio[N-1+k]  = prio[k];
    end
    for (int i = N - 2; i >= 0; i--) begin
      if (nValid[2*i+2] && (!nValid[2*i+1] || (nPrio[2*i+2] < nPrio[2*i+1]))) begin
        nIdx[i]  = nIdx[2*i+2];
        nPrio[i] = nPrio[2*i+2];
      end else begin
        nIdx[i]  = nIdx[2*i+1];
        nPrio[i] = nPrio[2*i+1];
      end
      nValid[i] = nValid[2*i+1] | nValid[2*i+2];
    end
  end

  assign winValid = nValid[0];
  assign winIdx   = nIdx[0];
  assign winPrio  = nPrio[0];
endmodule

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  input  logic                        regWe,
  output logic [DATA_W-1:0]           regRdata,
  input  logic [SRC_N-1:0]            statusQ,
  input  winner_t                     irqWinQ,
  input  winner_t                     fiqWinQ,
  output logic [SRC_N-1:0]            maskQ,
  output logic [SRC_N-1:0]            fastSel,
  output logic [SRC_N-1:0]            edgeSel,
  output logic [SRC_N-1:0][PRIO_W-1:0] prioQ,
  output ctrlStrobe_t                 strobe
);
  localparam bit FAST_ALLOWED = (BANK_ID == 0);

  logic             isCfg;
  logic [IDX_W-1:0] cfgIdx;
  assign isCfg  = regAddr[ADDR_W-1];
  assign cfgIdx = regAddr[IDX_W-1:0];

  always_comb begin
    strobe.ackIrq   = regWe && !isCfg && (regAddr == ADDR_W'(ADDR_CTRL)) && regWdata[0];
    strobe.ackFiq   = regWe && !isCfg && (regAddr == ADDR_W'(ADDR_CTRL)) && regWdata[1];
    strobe.statusWr = regWe && !isCfg && (regAddr == ADDR_W'(ADDR_STATUS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (regWe && !isCfg && (regAddr == ADDR_W'(ADDR_MASK))) begin
      maskQ <= regWdata[SRC_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastSel <= '0;
      edgeSel <= '0;
      prioQ   <= '0;
    end else begin
      for (int k = 0; k < SRC_N; k++) begin
        if (regWe && isCfg && (cfgIdx == IDX_W'(k))) begin
          fastSel[k] <= FAST_ALLOWED ? regWdata[CFG_FAST_BIT] : 1'b0;
          edgeSel[k] <= regWdata[CFG_EDGE_BIT];
          prioQ[k]   <= regWdata[CFG_PRIO_LSB +: PRIO_W];
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (isCfg) begin
      regRdata[CFG_FAST_BIT]             = fastSel[cfgIdx];
      regRdata[CFG_EDGE_BIT]             = edgeSel[cfgIdx];
      regRdata[CFG_PRIO_LSB +: PRIO_W]   = prioQ[cfgIdx];
    end else begin
      case (regAddr)
        ADDR_W'(ADDR_STATUS):   regRdata = DATA_W'(statusQ);
        ADDR_W'(ADDR_MASK):     regRdata = DATA_W'(maskQ);
        ADDR_W'(ADDR_SORT_IRQ): regRdata = irqWinQ.valid ? DATA_W'({1'b1, irqWinQ.idx}) : '0;
        ADDR_W'(ADDR_SORT_FIQ): regRdata = fiqWinQ.valid ? DATA_W'({1'b1, fiqWinQ.idx}) : '0;
        default:                regRdata = '0;
      endcase
    end
  end

  // Mask register takes the written word (R4)
  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !isCfg && regAddr == ADDR_W'(ADDR_MASK)) |=> (maskQ == $past(regWdata[SRC_N-1:0])));

  // Configuration word fields land in the addressed source (R2)
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && isCfg) |=> ((prioQ[$past(cfgIdx)] == $past(regWdata[CFG_PRIO_LSB +: PRIO_W]))
                          && (edgeSel[$past(cfgIdx)] == $past(regWdata[CFG_EDGE_BIT]))));
endmodule

// File: rtl/intc_datapath.sv
`timescale 1ns/1ps
module intc_datapath
  import intc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SRC_N-1:0]             srcIn,
  input  logic [SRC_N-1:0]             maskQ,
  input  logic [SRC_N-1:0]             fastSel,
  input  logic [SRC_N-1:0]             edgeSel,
  input  logic [SRC_N-1:0][PRIO_W-1:0] prioQ,
  input  ctrlStrobe_t                  strobe,
  input  logic [DATA_W-1:0]            wdata,
  output logic [SRC_N-1:0]             statusQ,
  output winner_t                      irqWinQ,
  output winner_t                      fiqWinQ,
  output logic                         irqOut,
  output logic                         fiqOut
);
  logic [SRC_N-1:0] prevIn, riseEdge, pend, irqCand, fiqCand;
  logic [SRC_N-1:0] ackHit, wrClr, statusNext;
  winner_t irqArb, fiqArb;

  assign riseEdge = srcIn & ~prevIn & edgeSel;
  assign pend     = statusQ & ~maskQ;
  assign irqCand  = pend & ~fastSel;
  assign fiqCand  = pend & fastSel;
  assign wrClr    = strobe.statusWr ? ~wdata[SRC_N-1:0] : '0;

  always_comb begin
    ackHit = '0;
    if (strobe.ackIrq && irqWinQ.valid) ackHit[irqWinQ.idx] = 1'b1;
    if (strobe.ackFiq && fiqWinQ.valid) ackHit[fiqWinQ.idx] = 1'b1;
  end

  // New edges take precedence over any clear in the same cycle
  assign statusNext = (edgeSel & (riseEdge | (statusQ & ~(ackHit | wrClr))))
                    | (~edgeSel & srcIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      statusQ <= '0;
    end else begin
      prevIn  <= srcIn;
      statusQ <= statusNext;
    end
  end

  intc_arbiter #(.N(SRC_N), .PW(PRIO_W)) u_irqArb (
    .cand(irqCand), .prio(prioQ),
    .winValid(irqArb.valid), .winIdx(irqArb.idx), .winPrio(irqArb.prio)
  );

  intc_arbiter #(.N(SRC_N), .PW(PRIO_W)) u_fiqArb (
    .cand(fiqCand), .prio(prioQ),
    .winValid(fiqArb.valid), .winIdx(fiqArb.idx), .winPrio(fiqArb.prio)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqWinQ <= '0;
      fiqWinQ <= '0;
    end else begin
      irqWinQ <= irqArb;
      fiqWinQ <= fiqArb;
    end
  end

  assign irqOut = irqWinQ.valid;
  assign fiqOut = fiqWinQ.valid;

  // A rising edge always leaves the bit set, even against a clear (R12, R5)
  assert_edge_capture_R12: assert property (@(posedge clk) disable iff (!rstN)
    (riseEdge != '0) |=> ((statusQ & $past(riseEdge)) == $past(riseEdge)));

  // Level sources mirror the input one clock later (R5)
  assert_level_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(edgeSel)) == ($past(srcIn) & ~$past(edgeSel))));

  // Retiring an edge winner clears it when no new edge arrives (R9)
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackIrq && irqWinQ.valid && edgeSel[irqWinQ.idx] && !riseEdge[irqWinQ.idx])
      |=> !statusQ[$past(irqWinQ.idx)]);

  // Outputs reflect the candidates of the previous cycle (R8, R11)
  assert_irq_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|irqCand)));
  assert_fiq_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiqOut == $past(|fiqCand)));

  // Winner is an unmasked pending source (R4) and no candidate beats it (R6)
  always @(posedge clk) begin
    if (rstN && irqArb.valid) begin
      assert_win_pending_R4: assert (irqCand[irqArb.idx]);
      for (int k = 0; k < SRC_N; k++) begin
        if (irqCand[k]) begin
          assert_prio_order_R6: assert ((irqArb.prio < prioQ[k]) ||
            ((irqArb.prio == prioQ[k]) && (irqArb.idx <= IDX_W'(k))));
        end
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
  import intc_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SRC_N-1:0]    srcIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic                regWe,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irqOut,
  output logic                fiqOut
);
  logic [SRC_N-1:0]             statusQ, maskQ, fastSel, edgeSel;
  logic [SRC_N-1:0][PRIO_W-1:0] prioQ;
  winner_t                      irqWinQ, fiqWinQ;
  ctrlStrobe_t                  strobe;

  intc_ctrl #(.BANK_ID(BANK_ID)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata),
    .statusQ(statusQ), .irqWinQ(irqWinQ), .fiqWinQ(fiqWinQ),
    .maskQ(maskQ), .fastSel(fastSel), .edgeSel(edgeSel), .prioQ(prioQ),
    .strobe(strobe)
  );

  intc_datapath u_datapath (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .maskQ(maskQ), .fastSel(fastSel), .edgeSel(edgeSel), .prioQ(prioQ),
    .strobe(strobe), .wdata(regWdata),
    .statusQ(statusQ), .irqWinQ(irqWinQ), .fiqWinQ(fiqWinQ),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/tb_intc_bank.sv
`timescale 1ns/1ps
module tb_intc_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWe = 1'b0;
  logic [31:0] regRdata, rdataB;
  logic        irqOut, fiqOut, irqOutB, fiqOutB;

  always #2.5 clk = ~clk;

  intc_bank #(.BANK_ID(0)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .irqOut(irqOut), .fiqOut(fiqOut));

  intc_bank #(.BANK_ID(1)) dutB (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(rdataB), .irqOut(irqOutB), .fiqOut(fiqOutB));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model of the bank-0 instance
  logic [31:0] mIn = '0, mLatch = '0, mMask = '1, mFast = '0, mEdge = '0;
  logic [4:0]  mPrio [32];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] effStatus();
    return (mEdge & mLatch) | (~mEdge & mIn);
  endfunction

  function automatic logic [31:0] expWin(input logic fast);
    logic [31:0] cand;
    logic found;
    logic [4:0] best, idx;
    cand  = effStatus() & ~mMask & (fast ? mFast : ~mFast);
    found = 1'b0; best = '0; idx = '0;
    for (int k = 0; k < 32; k++) begin
      if (cand[k] && (!found || mPrio[k] < best)) begin
        found = 1'b1; best = mPrio[k]; idx = 5'(k);
      end
    end
    return found ? {26'b0, 1'b1, idx} : 32'b0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d, output logic [31:0] dB);
    regAddr = a;
    #1;
    d = regRdata; dB = rdataB;
  endtask

  task automatic setIn(input logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    mLatch = mLatch | (v & ~mIn & mEdge);
    mIn = v;
  endtask

  task automatic setMask(input logic [31:0] v);
    busWrite(6'h01, v);
    mMask = v;
  endtask

  task automatic writeCfg(input int k, input logic f, input logic e, input logic [4:0] p);
    busWrite(6'(32 + k), {25'b0, p, e, f});
    if (e && !mEdge[k]) mLatch[k] = mIn[k];
    mFast[k] = f; mEdge[k] = e; mPrio[k] = p;
  endtask

  task automatic retire(input logic [1:0] bits);
    logic [31:0] wi, wf;
    wi = expWin(1'b0); wf = expWin(1'b1);
    busWrite(6'h04, {30'b0, bits});
    if (bits[0] && wi[5] && mEdge[wi[4:0]]) mLatch[wi[4:0]] = 1'b0;
    if (bits[1] && wf[5] && mEdge[wf[4:0]]) mLatch[wf[4:0]] = 1'b0;
  endtask

  task automatic statusWrite(input logic [31:0] v);
    busWrite(6'h00, v);
    mLatch = mLatch & v;
  endtask

  task automatic compareAll();
    logic [31:0] d, dB;
    idle(2);
    busRead(6'h02, d, dB); chk("R7 sorted normal", d, expWin(1'b0));
    busRead(6'h03, d, dB); chk("R7 sorted fast", d, expWin(1'b1));
    busRead(6'h00, d, dB); chk("R5 status", d, effStatus());
    chk("R8 irqOut", {31'b0, irqOut}, {31'b0, expWin(1'b0) != 0});
    chk("R8 fiqOut", {31'b0, fiqOut}, {31'b0, expWin(1'b1) != 0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dB;
    for (int k = 0; k < 32; k++) mPrio[k] = '0;
    void'($urandom(32'h5EED_0042));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    busRead(6'h01, d, dB); chk("R1 mask reset", d, 32'hFFFF_FFFF);
    busRead(6'h00, d, dB); chk("R1 status reset", d, 32'h0);
    busRead(6'h02, d, dB); chk("R1 sorted normal reset", d, 32'h0);
    busRead(6'h03, d, dB); chk("R1 sorted fast reset", d, 32'h0);
    chk("R1 outputs reset", {30'b0, irqOut, fiqOut}, 32'h0);

    // R2 configuration word layout, R3 fast bit dropped outside bank 0
    busWrite(6'(32 + 5), 32'hFFFF_FFFF);
    mFast[5] = 1'b1; mEdge[5] = 1'b1; mPrio[5] = 5'd31; mLatch[5] = mIn[5];
    busRead(6'(32 + 5), d, dB);
    chk("R2 cfg readback", d, 32'h7F);
    chk("R3 cfg readback bank1", dB, 32'h7E);

    // R3 routing: source 7 to fast in bank 0, to normal in bank 1
    writeCfg(7, 1'b1, 1'b0, 5'd2);
    setMask(~(32'h1 << 7));
    setIn(32'h1 << 7);
    idle(2);
    chk("R8 fast routed", {30'b0, irqOut, fiqOut}, 32'h1);
    chk("R3 bank1 normal routed", {30'b0, irqOutB, fiqOutB}, 32'h2);
    busRead(6'h03, d, dB);
    chk("R7 sorted fast src7", d, 32'h27);
    chk("R3 bank1 sorted fast empty", dB, 32'h0);
    busRead(6'h02, d, dB);
    chk("R3 bank1 sorted normal src7", dB, 32'h27);
    busRead(6'(32 + 7), d, dB);
    chk("R3 cfg bank1 src7", dB, 32'h08);
    setIn(32'h0);
    compareAll();

    // R11 latency of an edge source
    writeCfg(3, 1'b0, 1'b1, 5'd1);
    setMask(~(32'h1 << 3));
    setIn(32'h1 << 3);
    idle(1);
    busRead(6'h00, d, dB); chk("R11 status after one clock", d, 32'h8);
    busRead(6'h02, d, dB); chk("R11 sorted not yet", d, 32'h0);
    chk("R11 irqOut not yet", {31'b0, irqOut}, 32'h0);
    idle(1);
    busRead(6'h02, d, dB); chk("R11 sorted after two clocks", d, 32'h23);
    chk("R11 irqOut after two clocks", {31'b0, irqOut}, 32'h1);
    setIn(32'h0);
    compareAll();
    busRead(6'h00, d, dB); chk("R5 edge held after fall", d, 32'h8);

    // R12 new edge in the same cycle as a retire of the same source
    @(negedge clk);
    srcIn = 32'h8; regAddr = 6'h04; regWdata = 32'h1; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    mIn = 32'h8;
    busRead(6'h00, d, dB); chk("R12 edge beats retire", d, 32'h8);
    compareAll();

    // R9 retire alone, R11 stale winner for one clock
    busWrite(6'h04, 32'h1);
    mLatch[3] = 1'b0;
    busRead(6'h02, d, dB); chk("R11 sorted stale one clock", d, 32'h23);
    busRead(6'h00, d, dB); chk("R9 retire clears edge", d, 32'h0);
    idle(1);
    busRead(6'h02, d, dB); chk("R9 sorted empty after retire", d, 32'h0);
    chk("R9 irqOut low after retire", {31'b0, irqOut}, 32'h0);

    // R10 status write
    setIn(32'h0);
    setIn(32'h8);
    compareAll();
    statusWrite(32'hFFFF_FFFF);
    busRead(6'h00, d, dB); chk("R10 ones keep pending", d, 32'h8);
    statusWrite(~32'h8);
    busRead(6'h00, d, dB); chk("R10 zero clears pending", d, 32'h0);
    compareAll();

    // R6 tie and priority order, R9 level source survives retire
    setIn(32'h0);
    writeCfg(10, 1'b0, 1'b0, 5'd3);
    writeCfg(4, 1'b0, 1'b0, 5'd3);
    setMask(~((32'h1 << 10) | (32'h1 << 4)));
    setIn((32'h1 << 10) | (32'h1 << 4));
    idle(2);
    busRead(6'h02, d, dB); chk("R6 tie lower index", d, 32'h24);
    writeCfg(10, 1'b0, 1'b0, 5'd2);
    idle(2);
    busRead(6'h02, d, dB); chk("R6 smaller value wins", d, 32'h2A);
    retire(2'b01);
    idle(2);
    busRead(6'h02, d, dB); chk("R9 level not cleared", d, 32'h2A);
    compareAll();

    // R4 masked pending source stays out
    setMask(32'hFFFF_FFFF);
    idle(2);
    busRead(6'h02, d, dB); chk("R4 all masked", d, 32'h0);
    chk("R4 irqOut masked", {31'b0, irqOut}, 32'h0);
    busRead(6'h00, d, dB); chk("R4 status still pending", d, effStatus());

    // Constrained random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: setIn($urandom);
        1: setMask($urandom & $urandom);
        2: writeCfg(int'($urandom % 32), 1'($urandom), 1'($urandom), 5'($urandom % 4));
        3: retire(2'(1 + $urandom % 3));
        4: statusWrite($urandom | $urandom);
        default: setIn(mIn ^ (32'h1 << ($urandom % 32)));
      endcase
      compareAll();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule